// File: doc/BRIEF.md
# Bearing Message Serial Transmitter

This block turns a three-digit BCD bearing into a fixed seven-character ASCII report and sends it on an asynchronous serial line. A one-cycle send pulse captures the digits. The block then shifts out the whole report, one character after another with no gap. Each digit becomes ASCII by adding 0x30. The report brackets the digits with a leading marker, a separator, a constant quality digit and a carriage return.

The bit period is a parameter, given as clock cycles per bit. A second parameter inverts the line, for boards with an inverting external driver. A display strobe pulses on the first report after reset and then on every seventh report, which limits how often a downstream readout refreshes.

Top module: `bearing_msg_tx`

## Requirements
- R1: After reset and whenever no report is in flight, `ser_o` holds the idle level (1, or 0 when INVERT_LINE=1), and `busy_o` and `strobe_o` are low.
- R2: A high `send_i` sampled at a rising edge while `busy_o` is low starts a report. From that edge on, `busy_o` is high and the line carries a start bit.
- R3: A report is seven characters, in this order: 0x25 ('%'), hundreds+0x30, tens+0x30, units+0x30, 0x2F ('/'), 0x37 ('7'), 0x0D.
- R4: Each character is framed as one start bit (0), eight data bits with the least significant bit first, and one stop bit (1). Every bit lasts CLKS_PER_BIT cycles, and the next character's start bit follows the previous stop bit with no gap.
- R5: `busy_o` stays high for exactly 70*CLKS_PER_BIT cycles and falls when the carriage return's stop bit ends.
- R6: A send pulse while `busy_o` is high is ignored. Digit inputs that change after acceptance do not alter the report in flight.
- R7: `strobe_o` is a one-cycle pulse that is high in the first cycle of the 1st, 8th, 15th, ... report after reset.
- R8: With INVERT_LINE=1, `ser_o` is the bitwise complement of the non-inverted line in every cycle, including idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| send_i | input | 1 | Request to send one report |
| hund_i | input | 4 | BCD hundreds digit |
| tens_i | input | 4 | BCD tens digit |
| units_i | input | 4 | BCD units digit |
| ser_o | output | 1 | Serial line |
| busy_o | output | 1 | Report in flight |
| strobe_o | output | 1 | Display strobe, one report in seven |

## Verification
Reports are sent with several digit sets: all zeros, all nines, and mixed values. Comparing every bit against the model shows whether digits are mis-ordered or wrongly converted to ASCII. During one report the bench pulses send and changes the digits, which exposes a missing busy guard or a failure to latch the digits. In another run send is held high across a report boundary, which checks restart at the first idle edge and the exact length of `busy_o`. Fifteen reports are sent in total, so the strobe cadence is seen to wrap twice. A second instance with the inverted line is compared against the first in every cycle.

// File: rtl/bmt_pkg.sv
package bmt_pkg;
  localparam int unsigned MSG_CHARS  = 7;
  localparam int unsigned FRAME_BITS = 10;
  localparam logic [7:0] CH_LEAD  = 8'h25;
  localparam logic [7:0] CH_SEP   = 8'h2F;
  localparam logic [7:0] CH_QUAL  = 8'h37;
  localparam logic [7:0] CH_END   = 8'h0D;
  localparam logic [7:0] CH_ZERO  = 8'h30;

  function automatic logic [7:0] char_at(input logic [2:0] idx, input logic [3:0] h,
                                         input logic [3:0] t, input logic [3:0] u);
    case (idx)
      3'd0:    char_at = CH_LEAD;
      3'd1:    char_at = CH_ZERO + {4'd0, h};
      3'd2:    char_at = CH_ZERO + {4'd0, t};
      3'd3:    char_at = CH_ZERO + {4'd0, u};
      3'd4:    char_at = CH_SEP;
      3'd5:    char_at = CH_QUAL;
      default: char_at = CH_END;
    endcase
  endfunction
endpackage

// File: rtl/bmt_baud.sv
module bmt_baud #(
  parameter int unsigned CLKS_PER_BIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (en_i)    cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/bmt_char_ser.sv
module bmt_char_ser #(
  parameter int unsigned CLKS_PER_BIT = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] data_i,
  output logic       line_o,
  output logic       last_o
);
  import bmt_pkg::*;
  localparam int unsigned BW = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] STOP_POS = BW'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] sh_q;
  logic [BW-1:0]         bit_q;
  logic                  act_q;
  logic                  tick;

  bmt_baud #(.CLKS_PER_BIT(CLKS_PER_BIT)) baud_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (load_i),
    .en_i    (act_q),
    .tick_o  (tick)
  );

  assign last_o = tick && (bit_q == STOP_POS);
  assign line_o = act_q ? sh_q[0] : 1'b1;

  // load wins over the final tick so characters run back to back
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '1;
      bit_q <= '0;
      act_q <= 1'b0;
    end else if (load_i) begin
      sh_q  <= {1'b1, data_i, 1'b0};
      bit_q <= '0;
      act_q <= 1'b1;
    end else if (tick) begin
      sh_q <= {1'b1, sh_q[FRAME_BITS-1:1]};
      if (bit_q == STOP_POS) act_q <= 1'b0;
      else                   bit_q <= bit_q + 1'b1;
    end
  end
endmodule

// File: rtl/bmt_msg_div.sv
module bmt_msg_div #(
  parameter int unsigned PERIOD = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic strobe_o
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      strobe_o <= 1'b0;
    end else begin
      strobe_o <= start_i && (cnt_q == '0);
      if (start_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bearing_msg_tx.sv
module bearing_msg_tx #(
  parameter int unsigned CLKS_PER_BIT = 16,
  parameter bit          INVERT_LINE  = 1'b0,
  parameter int unsigned STROBE_EVERY = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       send_i,
  input  logic [3:0] hund_i,
  input  logic [3:0] tens_i,
  input  logic [3:0] units_i,
  output logic       ser_o,
  output logic       busy_o,
  output logic       strobe_o
);
  import bmt_pkg::*;
  localparam logic [2:0] LAST_CHAR = 3'(MSG_CHARS - 1);

  logic       busy_q;
  logic [2:0] idx_q;
  logic [3:0] h_q, t_q, u_q;
  logic       accept, ser_last, load, line;
  logic [7:0] next_char;

  assign accept    = send_i && !busy_q;
  assign load      = accept || (ser_last && idx_q != LAST_CHAR);
  assign next_char = char_at(accept ? 3'd0 : idx_q + 3'd1, h_q, t_q, u_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      h_q    <= '0;
      t_q    <= '0;
      u_q    <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      h_q    <= hund_i;
      t_q    <= tens_i;
      u_q    <= units_i;
    end else if (ser_last) begin
      if (idx_q == LAST_CHAR) busy_q <= 1'b0;
      else                    idx_q  <= idx_q + 1'b1;
    end
  end

  bmt_char_ser #(.CLKS_PER_BIT(CLKS_PER_BIT)) ser_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .data_i (next_char),
    .line_o (line),
    .last_o (ser_last)
  );

  bmt_msg_div #(.PERIOD(STROBE_EVERY)) div_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .strobe_o (strobe_o)
  );

  assign ser_o  = line ^ INVERT_LINE;
  assign busy_o = busy_q;
endmodule

// File: rtl/bearing_msg_tx_chk.sv
module bearing_msg_tx_chk #(
  parameter bit INVERT_LINE = 1'b0
) (
  input logic clk_i,
  input logic rst_ni,
  input logic send_i,
  input logic ser_o,
  input logic busy_o,
  input logic strobe_o
);
  localparam logic IDLE = ~INVERT_LINE;

  assert_idle_level_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> ser_o == IDLE);

  assert_start_bit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ser_o == ~IDLE);

  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_i && !busy_o) |=> busy_o);

  assert_end_on_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(ser_o) == IDLE);

  assert_busy_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> busy_o);

  assert_strobe_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);

  assert_strobe_at_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> $rose(busy_o));
endmodule

bind bearing_msg_tx bearing_msg_tx_chk #(.INVERT_LINE(INVERT_LINE)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .send_i   (send_i),
  .ser_o    (ser_o),
  .busy_o   (busy_o),
  .strobe_o (strobe_o)
);

// File: tb/bearing_msg_tx_tb_top.sv
module bearing_msg_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CPB        = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic send = 1'b0;
  logic [3:0] hund = '0, tens = '0, units = '0;
  logic ser, busy, strobe, ser_inv, busy_inv, strobe_inv;

  int n_tests = 0, n_fail = 0;
  int n_msgs = 0, n_strobes = 0, busy_len = 0;
  bit exp_q[$];
  bit exp_strobe = 1'b0;
  int model_cnt = 0;
  bit busy_d = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bearing_msg_tx #(.CLKS_PER_BIT(CPB), .INVERT_LINE(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .send_i(send), .hund_i(hund), .tens_i(tens),
    .units_i(units), .ser_o(ser), .busy_o(busy), .strobe_o(strobe));

  bearing_msg_tx #(.CLKS_PER_BIT(CPB), .INVERT_LINE(1'b1)) dut_inv_i (
    .clk_i(clk), .rst_ni(rst_n), .send_i(send), .hund_i(hund), .tens_i(tens),
    .units_i(units), .ser_o(ser_inv), .busy_o(busy_inv), .strobe_o(strobe_inv));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push_char(input logic [7:0] c);
    logic [9:0] f;
    f = {1'b1, c, 1'b0};
    for (int b = 0; b < 10; b++)
      for (int k = 0; k < CPB; k++) exp_q.push_back(f[b]);
  endtask

  // behavioural reference: per-cycle line levels in a queue
  always @(posedge clk) begin
    bit was_busy;
    if (!rst_n) begin
      exp_q.delete();
      exp_strobe = 1'b0;
      model_cnt = 0;
    end else begin
      was_busy = exp_q.size() > 0;
      if (was_busy) void'(exp_q.pop_front());
      exp_strobe = 1'b0;
      if (!was_busy && send) begin
        push_char(8'h25);
        push_char(8'h30 + {4'd0, hund});
        push_char(8'h30 + {4'd0, tens});
        push_char(8'h30 + {4'd0, units});
        push_char(8'h2F);
        push_char(8'h37);
        push_char(8'h0D);
        exp_strobe = (model_cnt % 7) == 0;
        model_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    bit e_ser, e_busy;
    if (!rst_n) begin
      chk(ser == 1'b1 && busy == 1'b0 && strobe == 1'b0, "R1 reset", {ser, busy, strobe}, 3'b100);
    end else begin
      e_busy = exp_q.size() > 0;
      e_ser  = e_busy ? exp_q[0] : 1'b1;
      chk(ser == e_ser, "R3 R4 R6 line", ser, e_ser);
      chk(busy == e_busy, "R5 R6 busy", busy, e_busy);
      chk(strobe == exp_strobe, "R7 strobe", strobe, exp_strobe);
      chk(ser_inv == ~ser, "R8 inverted line", ser_inv, !ser);
      if (!e_busy) chk(ser == 1'b1, "R1 idle", ser, 1);
      if (busy && !busy_d) chk(ser == 1'b0, "R2 start bit", ser, 0);
      if (busy) busy_len++;
      if (!busy && busy_d) begin
        chk(busy_len == 70*CPB, "R5 busy length", busy_len, 70*CPB);
        busy_len = 0;
      end
      if (busy && !busy_d) n_msgs++;
      if (strobe) n_strobes++;
      busy_d = busy;
    end
  end

  task automatic send_msg(input logic [3:0] h, input logic [3:0] t, input logic [3:0] u,
                          input bit disturb);
    @(negedge clk);
    hund = h; tens = t; units = u; send = 1'b1;
    @(negedge clk);
    send = 1'b0;
    if (disturb) begin
      repeat (13*CPB) @(negedge clk);
      send = 1'b1; hund = 4'd8; tens = 4'd8; units = 4'd8;   // R6 ignored
      @(negedge clk);
      send = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R6 no extra report", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    send_msg(4'd3, 4'd5, 4'd9, 1'b0);
    send_msg(4'd0, 4'd0, 4'd0, 1'b1);
    send_msg(4'd9, 4'd9, 4'd9, 1'b0);
    // held send: back-to-back reports
    @(negedge clk);
    hund = 4'd2; tens = 4'd7; units = 4'd1; send = 1'b1;
    repeat (2*70*CPB + 3) @(negedge clk);
    send = 1'b0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 9; i++) send_msg(4'(i % 4), 4'(i), 4'(9 - i), 1'b0);
    chk(n_msgs == 15, "R2 report count", n_msgs, 15);
    chk(n_strobes == 3, "R7 strobe count", n_strobes, 3);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule